// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block tells odd television fields from even ones. It watches the active edges of the horizontal and vertical sync inputs and measures how far into the current line each vertical edge lands. If that edge comes in the first half of the line, the field is even. If it comes in the second half, the field is odd. The result drives `frame_out`, a level that an external vertical deflection stage uses to shift alternate fields, so that interlaced lines lie on top of each other and text does not flicker.

The line period is not fixed. The block measures it by counting clocks between successive horizontal edges. Half of that count is the boundary between the two halves of a line. A guard band of one sixteenth of the line sits around the line start and around the midpoint. When a vertical edge falls inside that band, the position test is unreliable, so the block takes the inverse of the previous field's parity. This keeps the output alternating cleanly even when the two syncs are nearly coincident.

Three control inputs shape the result:
- A force bit holds the output low.
- An auto bit lets the output run only while no video is shown.
- A flip bit inverts the field flag exported to the vertical timing logic. It leaves `frame_out` alone.

Top module: `field_parity_det`

## Requirements
- R1: After reset, `frame_out` is 0 and the stored parity is 0, so `field_odd` equals `field_flip`.
- R2: The line length L is the number of clocks between two successive active HSync edges. The position of a VSync active edge is the number of clocks since the latest active HSync edge, where 0 means the two edges coincide.
- R3: A VSync edge at a position p with p < L/2, lying outside the guard band, sets parity 0 (even field), and `frame_out` becomes 0.
- R4: A VSync edge at a position p with p >= L/2, lying outside the guard band, sets parity 1 (odd field), and `frame_out` becomes 1.
- R5: With g = L/16 (integer division), a position is in the guard band when any of these holds: p < g, p + g >= L, or |p - L/2| < g. A VSync edge in the guard band sets parity to the inverse of the previous parity. While no line has been measured (L = 0), every VSync edge counts as in the guard band.
- R6: Parity changes only at a VSync active edge. The change is visible on the outputs 3 rising clock edges after the VSync input changes, and not after 2.
- R7: While `force_low` is 1, `frame_out` is 0 whatever the parity. The stored parity is kept.
- R8: While `auto_text` and `video_on` are both 1, `frame_out` is 0. With `video_on` at 0, or with `auto_text` at 0, `frame_out` follows the parity.
- R9: `field_odd` equals parity XOR `field_flip`. `field_flip` changes neither `frame_out` nor the parity decision.
- R10: Only the active sync edge counts. A trailing VSync edge leaves the parity unchanged. The active polarity of each sync is a parameter, and rising is the default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| vsync_in | input | 1 | Vertical sync, asynchronous |
| force_low | input | 1 | Holds `frame_out` at 0 |
| auto_text | input | 1 | Enables gating of `frame_out` by `video_on` |
| field_flip | input | 1 | Inverts the exported field flag |
| video_on | input | 1 | Video is being displayed |
| frame_out | output | 1 | Field parity level for the deflection stage |
| field_odd | output | 1 | Field flag for the vertical timing logic |

## Verification
Each sync input passes through two synchronising flops and one edge-reference flop. The parity register therefore takes a new value on the third rising edge after a VSync input change, and the bench samples `frame_out` and `field_odd` at falling edges only after that point. One dedicated check confirms the value is still old after two edges and new after three. The control bits act combinationally on the stored parity, so they are checked one falling edge after they are driven. Line timing is generated cycle by cycle, which places each VSync edge at an exact position from 0 to L-1. The expected parity for every position is computed in the bench from the half-line and guard-band arithmetic, for line lengths of 64 and 96.

// File: rtl/field_parity_det.sv
`timescale 1ns/1ps
module field_parity_det #(
  parameter int CNT_W       = 12,
  parameter int GUARD_SHIFT = 4,
  parameter bit HS_RISE     = 1'b1,
  parameter bit VS_RISE     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_in,
  input  logic vsync_in,
  input  logic force_low,
  input  logic auto_text,
  input  logic field_flip,
  input  logic video_on,
  output logic frame_out,
  output logic field_odd
);

  localparam logic HS_INV = ~HS_RISE;
  localparam logic VS_INV = ~VS_RISE;
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [2:0] hs_sr, vs_sr;
  logic       hs_edge, vs_edge;
  logic [CNT_W-1:0] pos, line_len, vpos;
  logic [CNT_W:0]   len_x, vpos_x, half_x, g_x;
  logic       near_start, near_mid, ambig, pos_odd;
  logic       odd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_sr <= '0;
      vs_sr <= '0;
    end else begin
      hs_sr <= {hs_sr[1:0], hsync_in ^ HS_INV};
      vs_sr <= {vs_sr[1:0], vsync_in ^ VS_INV};
    end

  assign hs_edge = hs_sr[1] & ~hs_sr[2];
  assign vs_edge = vs_sr[1] & ~vs_sr[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos      <= '0;
      line_len <= '0;
    end else if (hs_edge) begin
      pos      <= {{(CNT_W-1){1'b0}}, 1'b1};
      line_len <= pos;
    end else if (pos != POS_MAX) begin
      pos <= pos + 1'b1;
    end

  assign vpos   = hs_edge ? '0 : pos;
  assign len_x  = {1'b0, line_len};
  assign vpos_x = {1'b0, vpos};
  assign half_x = len_x >> 1;
  assign g_x    = len_x >> GUARD_SHIFT;

  assign near_start = (vpos_x < g_x) || (vpos_x + g_x >= len_x);
  assign near_mid   = (vpos_x + g_x > half_x) && (vpos_x < half_x + g_x);
  assign ambig      = (line_len == '0) || near_start || near_mid;
  assign pos_odd    = vpos_x >= half_x;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       odd_q <= 1'b0;
    else if (vs_edge) odd_q <= ambig ? ~odd_q : pos_odd;

  assign frame_out = odd_q & ~force_low & ~(auto_text & video_on);
  assign field_odd = odd_q ^ field_flip;

  // R6
  parity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_edge |=> $stable(odd_q));

  // R5
  ambig_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_edge && ambig) |=> (odd_q != $past(odd_q)));

  // R2
  pos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_edge |=> (pos == {{(CNT_W-1){1'b0}}, 1'b1}));

  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |-> !frame_out);

  // R9
  flip_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_out |-> (field_odd != field_flip));

  // R10
  trail_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_sr[2]) |=> $stable(odd_q));

endmodule

// File: tb/field_parity_det_tb.sv
`timescale 1ns/1ps
module field_parity_det_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hsync = 1'b0, vsync = 1'b0;
  logic force_low = 1'b0, auto_text = 1'b0, field_flip = 1'b0, video_on = 1'b0;
  logic frame_out, field_odd;
  int checks = 0, errors = 0;
  int line_p = 64;
  int vleft = 0;
  logic exp_par = 1'b0;

  always #2.5 clk = ~clk;

  field_parity_det dut_i (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync), .vsync_in(vsync),
    .force_low(force_low), .auto_text(auto_text), .field_flip(field_flip),
    .video_on(video_on), .frame_out(frame_out), .field_odd(field_odd));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Drives n lines of length line_p; VSync rises at position v of the first line (v<0: none).
  task automatic run_lines(input int n, input int v);
    for (int l = 0; l < n; l++)
      for (int k = 0; k < line_p; k++) begin
        @(negedge clk);
        hsync = (k < 8);
        if (l == 0 && k == v) vleft = 4;
        vsync = (vleft > 0);
        if (vleft > 0) vleft--;
      end
  endtask

  function automatic logic model(input int v, input logic prev);
    int g = line_p >> 4;
    int h = line_p >> 1;
    if (v < g || v + g >= line_p || (v + g > h && v < h + g)) return ~prev;
    return (v >= h);
  endfunction

  task automatic field(input int v, input string req);
    run_lines(3, v);
    exp_par = model(v, exp_par);
    chk(req, frame_out, exp_par);
    chk({req, " field_odd"}, field_odd, exp_par ^ field_flip);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R6 watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 frame", frame_out, 1'b0);
    chk("R1 field_odd", field_odd, 1'b0);

    // R5: no line measured yet, edge is ambiguous -> toggle to 1
    vsync = 1'b1; repeat (6) @(negedge clk); vsync = 1'b0; repeat (6) @(negedge clk);
    exp_par = 1'b1;
    chk("R5 unmeasured", frame_out, 1'b1);

    // R6 latency: still unmeasured, toggle back to 0
    vsync = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 two edges", frame_out, 1'b1);
    @(negedge clk);
    chk("R6 three edges", frame_out, 1'b0);
    exp_par = 1'b0;
    repeat (4) @(negedge clk);
    // R10 trailing edge
    vsync = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 trailing", frame_out, 1'b0);

    // R2 R3 R4 R5 sweep, L=64
    run_lines(3, -1);
    for (int v = 0; v < 64; v++) field(v, "R3 R4 R5 sweep L64");

    // R9: flip does not change decision
    field_flip = 1'b1;
    field(10, "R9 flip even");
    field(45, "R9 flip odd");
    field(31, "R9 flip ambig");
    field_flip = 1'b0;

    // R2 other line length
    line_p = 96;
    run_lines(3, -1);
    for (int v = 0; v < 96; v += 3) field(v, "R2 sweep L96");

    // controls, put parity to 1
    line_p = 64;
    run_lines(3, -1);
    field(40, "R4 setup");
    force_low = 1'b1; @(negedge clk);
    chk("R7 force", frame_out, 1'b0);
    chk("R7 kept", field_odd, 1'b1);
    force_low = 1'b0; @(negedge clk);
    chk("R7 release", frame_out, 1'b1);
    auto_text = 1'b1; video_on = 1'b1; @(negedge clk);
    chk("R8 video gated", frame_out, 1'b0);
    video_on = 1'b0; @(negedge clk);
    chk("R8 text only", frame_out, 1'b1);
    auto_text = 1'b0; video_on = 1'b1; @(negedge clk);
    chk("R8 auto off", frame_out, 1'b1);
    video_on = 1'b0;
    field_flip = 1'b1; @(negedge clk);
    chk("R9 frame unaffected", frame_out, 1'b1);
    chk("R9 flag inverted", field_odd, 1'b0);
    field_flip = 1'b0;
    field(12, "R3 after controls");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule